// File: doc/BRIEF.md
# Variable-Length Bundle Fetch Buffer

This block sits between a narrow program memory port and a wide execution stage. The port returns fixed packets of four instruction words. The execution stage consumes bundles of one to ten words. Every stored word carries an end-of-bundle flag. The buffer collects packets into a 16-word circular store. It emits a bundle once every word from the read head up to and including the first flagged word is present. Packet boundaries and bundle boundaries are independent of each other, so one bundle may straddle two or three packets.

The block also runs hardware loops. A loop command gives the addresses of the first and last word of the body and an iteration count. If the body fits in the store, the body is fetched once and the later iterations replay from the store with no program memory traffic. If the body is larger than the store, each iteration fetches the body again from memory. Leaving a buffered loop, or taking a branch, empties the store and restarts fetching at the new address.

Top module: `bundle_fetch_buffer`

## Requirements
- R1: While reset is low, `bnd_valid` and `fetch_req` are low and `fetch_addr` is 0. The first request after reset reads address 0.
- R2: At most one fetch is outstanding at a time. A request is raised only when at least 4 of the 16 slots are free, so the store never holds more than 16 words.
- R3: Each input packet holds word j in bits [17j+16:17j]. Bit 17j+16 is that word's end-of-bundle flag and the lower 16 bits are its data. A bundle runs from the read head through the first flagged word, and `bnd_len` is between 1 and 10. Bundle word k is placed at `bnd_words[16k+15:16k]`, and lanes at or beyond `bnd_len` read as zero.
- R4: Bundles leave in program order, whatever the packet alignment. `bnd_pc` is the address of the bundle's first word.
- R5: While `bnd_valid` is high and `bnd_ready` is low, with no branch or loop command, the bundle outputs stay unchanged in the next cycle.
- R6: A branch empties the store, and the next bundle starts at the target. A response to a request made before the branch is discarded. In the cycle after a branch, `bnd_valid` is low.
- R7: For a loop body of L words with L at most 16, all iterations together issue exactly ceil(L/4) fetch requests. The bundle sequence repeats from the first body word.
- R8: For a loop body of more than 16 words, each iteration fetches the body again from memory, and the bundle sequence still repeats from the first body word.
- R9: After the last iteration, the next bundle starts at the address one past the last body word.
- R10: An iteration count of 0 runs the body once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | output | 1 | Fetch request, accepted on the clock edge where it is high |
| fetch_addr | output | 16 | Address of the first word of the requested packet |
| fetch_rsp_valid | input | 1 | Packet response valid |
| fetch_rsp_pkt | input | 68 | Four words, each made of a flag bit and 16 data bits |
| bnd_valid | output | 1 | Bundle available |
| bnd_ready | input | 1 | Execution stage takes the bundle |
| bnd_len | output | 4 | Number of words in the bundle |
| bnd_words | output | 160 | Bundle words, word 0 in the lowest lane |
| bnd_pc | output | 16 | Address of the bundle's first word |
| br_valid | input | 1 | Taken branch, empties the store |
| br_target | input | 16 | Branch target address |
| loop_start | input | 1 | Loop command |
| loop_first | input | 16 | Address of the first body word |
| loop_last | input | 16 | Address of the last body word, which must end a bundle |
| loop_count | input | 8 | Iteration count |

## Verification
A corrupted head, occupancy or read offset shows up at the very next handshake as a wrong `bnd_pc`, a wrong length or a swapped data lane. The bench therefore compares every handshake with an address-derived program image. A stale packet written after a flush shows up within one bundle of the branch or loop command. An iteration counter that is off by one, or a lost held-body flag, shows up at loop exit as a wrong next address or an excess fetch count. Sweeps over branch timing, memory latency, loop start, body length across the 16-word limit, and iteration counts 0 to 3 expose each of these within a few cycles of the event.

// File: rtl/fbuf_pkg.sv
`timescale 1ns/1ps
// Shared types for the bundle fetch buffer.
package fbuf_pkg;
    // Operating mode of the buffer.
    typedef enum logic [1:0] {
        FB_LINEAR       = 2'd0,  // sequential fetch; consumed words are freed
        FB_LOOP_HELD    = 2'd1,  // loop body kept in the store and replayed
        FB_LOOP_REFETCH = 2'd2   // body too large; memory is read again each pass
    } fb_mode_e;
endpackage

// File: rtl/fbuf_store.sv
`timescale 1ns/1ps
// Circular word store.
// Writes up to PKT_W words per cycle, starting at wr_base.
// Presents a window of WIN consecutive entries starting at rd_base.
// Assumes DEPTH is a power of two, so that indices wrap naturally.
// Data entries carry no reset; validity is tracked by the owner.
module fbuf_store #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 16,
    parameter int PKT_W  = 4,
    parameter int WIN    = 10,
    localparam int E     = WORD_W + 1,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PC_W  = $clog2(PKT_W + 1)
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_base,
    input  logic [PC_W-1:0]    wr_cnt,
    input  logic [PKT_W*E-1:0] wr_pkt,
    input  logic [IDX_W-1:0]   rd_base,
    output logic [WIN*E-1:0]   rd_win
);
    logic [E-1:0] mem [DEPTH];

    // Write the leading wr_cnt words of the packet into consecutive slots.
    always_ff @(posedge clk) begin
        for (int j = 0; j < PKT_W; j++) begin
            if (wr_en && j < int'(wr_cnt))
                mem[wr_base + IDX_W'(j)] <= wr_pkt[j*E +: E];
        end
    end

    // One window lane per possible bundle word, wrapping around the store.
    for (genvar k = 0; k < WIN; k++) begin : g_win
        assign rd_win[k*E +: E] = mem[rd_base + IDX_W'(k)];
    end
endmodule

// File: rtl/fbuf_scan.sv
`timescale 1ns/1ps
// Bundle boundary finder.
// Searches the first `avail` window entries for the first end-of-bundle flag.
// It reports whether a complete bundle is present, its length, and its words
// with the unused lanes forced to zero. Purely combinational.
module fbuf_scan #(
    parameter int WORD_W = 16,
    parameter int WIN    = 10,
    parameter int OCC_W  = 5,
    localparam int E     = WORD_W + 1,
    localparam int LEN_W = $clog2(WIN + 1)
) (
    input  logic [WIN*E-1:0]      rd_win,
    input  logic [OCC_W-1:0]      avail,
    output logic                  found,
    output logic [LEN_W-1:0]      len,
    output logic [WIN*WORD_W-1:0] words
);
    // Priority search for the first flagged word, then masked lane copy.
    always_comb begin
        found = 1'b0;
        len   = '0;
        words = '0;
        for (int k = 0; k < WIN; k++) begin
            if (!found && k < int'(avail) && rd_win[k*E + WORD_W]) begin
                found = 1'b1;
                len   = LEN_W'(k + 1);
            end
        end
        for (int k = 0; k < WIN; k++) begin
            if (k < int'(len))
                words[k*WORD_W +: WORD_W] = rd_win[k*E +: WORD_W];
        end
    end
endmodule

// File: rtl/fbuf_fetch.sv
`timescale 1ns/1ps
// Fetch sequencer.
// Issues at most one packet request at a time and advances the address by
// PKT_W per request. On a flush it redirects to flush_pc. If a request is
// still in flight at the flush, it marks the coming response as stale, so
// that response is dropped.
module fbuf_fetch #(
    parameter int ADDR_W               = 16,
    parameter int PKT_W                = 4,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              can_fetch,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_pc,
    input  logic              rsp_valid,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              rsp_take
);
    logic              pend;
    logic              drop;
    logic [ADDR_W-1:0] fpc;

    // Request only when idle, out of reset, with room, and not redirecting.
    assign fetch_req  = rst_n && !pend && can_fetch && !flush;
    assign fetch_addr = fpc;
    // A response is used only if it is current and no flush is happening.
    assign rsp_take   = rsp_valid && pend && !drop && !flush;

    // Outstanding-request tracking and fetch address update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            drop <= 1'b0;
            fpc  <= RESET_PC;
        end else if (flush) begin
            fpc <= flush_pc;
            if (pend && !rsp_valid) begin
                drop <= 1'b1;
            end else begin
                pend <= 1'b0;
                drop <= 1'b0;
            end
        end else begin
            if (fetch_req) begin
                pend <= 1'b1;
                fpc  <= fpc + ADDR_W'(PKT_W);
            end
            if (rsp_valid && pend) begin
                pend <= 1'b0;
                drop <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bundle_fetch_buffer.sv
`timescale 1ns/1ps
// Variable-length bundle fetch buffer.
// Collects fixed packets of PKT_W words into a DEPTH-word circular store. It
// emits bundles of up to MAX_BND words, each ending at the first word whose
// end-of-bundle flag is set. It also runs hardware loops, replaying bodies of
// at most DEPTH words from the store and refetching larger bodies.
// Assumes: DEPTH is a power of two and at least PKT_W + MAX_BND; every
// bundle is at most MAX_BND words; a loop's last word ends a bundle; and the
// loop starts on a bundle boundary.
module bundle_fetch_buffer
    import fbuf_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int ADDR_W   = 16,
    parameter int PKT_W    = 4,
    parameter int MAX_BND  = 10,
    parameter int DEPTH    = 16,
    parameter int CNT_W    = 8,
    parameter logic [ADDR_W-1:0] RESET_PC = '0,
    localparam int E       = WORD_W + 1,
    localparam int LEN_W   = $clog2(MAX_BND + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic                      fetch_req,
    output logic [ADDR_W-1:0]         fetch_addr,
    input  logic                      fetch_rsp_valid,
    input  logic [PKT_W*E-1:0]        fetch_rsp_pkt,
    output logic                      bnd_valid,
    input  logic                      bnd_ready,
    output logic [LEN_W-1:0]          bnd_len,
    output logic [MAX_BND*WORD_W-1:0] bnd_words,
    output logic [ADDR_W-1:0]         bnd_pc,
    input  logic                      br_valid,
    input  logic [ADDR_W-1:0]         br_target,
    input  logic                      loop_start,
    input  logic [ADDR_W-1:0]         loop_first,
    input  logic [ADDR_W-1:0]         loop_last,
    input  logic [CNT_W-1:0]          loop_count
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam int PC_W  = $clog2(PKT_W + 1);

    fb_mode_e           mode;
    logic [IDX_W-1:0]   head;
    logic [OCC_W-1:0]   occ;        // words held in the store
    logic [OCC_W-1:0]   off;        // words already replayed in held mode
    logic [OCC_W-1:0]   fetched;    // body words written in held mode
    logic [OCC_W-1:0]   body_len;
    logic [ADDR_W-1:0]  rpc;        // address of the word at the read point
    logic [ADDR_W-1:0]  lp_first;
    logic [ADDR_W-1:0]  lp_last;
    logic [CNT_W-1:0]   iters;      // passes left, including the current one

    logic [MAX_BND*E-1:0] win;
    logic [OCC_W-1:0]   avail;
    logic [OCC_W-1:0]   remain;
    logic [PC_W-1:0]    wr_cnt;
    logic [ADDR_W-1:0]  span_in;
    logic [ADDR_W-1:0]  last_addr;
    logic [ADDR_W-1:0]  flush_pc;
    logic               fits_in, body_done, can_fetch, rsp_take;
    logic               hs, at_end, wrap, exit_l, int_flush, flush;

    // Loop geometry and the end-of-body condition.
    always_comb begin
        span_in   = loop_last - loop_first;
        fits_in   = (loop_last >= loop_first) && (span_in < ADDR_W'(DEPTH));
        avail     = occ - off;
        remain    = body_len - fetched;
        body_done = (mode == FB_LOOP_HELD) && (fetched >= body_len);
        wr_cnt    = (mode == FB_LOOP_HELD && int'(remain) < PKT_W)
                    ? PC_W'(remain) : PC_W'(PKT_W);
        can_fetch = (int'(occ) <= DEPTH - PKT_W) && !body_done;
        hs        = bnd_valid && bnd_ready;
        last_addr = rpc + ADDR_W'(bnd_len) - 1'b1;
        at_end    = hs && (mode != FB_LINEAR) && (last_addr == lp_last);
        wrap      = at_end && (iters > CNT_W'(1));
        exit_l    = at_end && !wrap;
    end

    // Redirect selection: external commands first, then loop wrap or exit.
    always_comb begin
        int_flush = (wrap && mode == FB_LOOP_REFETCH) || (exit_l && mode == FB_LOOP_HELD);
        flush     = br_valid || loop_start || int_flush;
        if (br_valid)        flush_pc = br_target;
        else if (loop_start) flush_pc = loop_first;
        else if (wrap)       flush_pc = lp_first;
        else                 flush_pc = lp_last + 1'b1;
    end

    fbuf_fetch #(.ADDR_W(ADDR_W), .PKT_W(PKT_W), .RESET_PC(RESET_PC)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .can_fetch (can_fetch),
        .flush     (flush),
        .flush_pc  (flush_pc),
        .rsp_valid (fetch_rsp_valid),
        .fetch_req (fetch_req),
        .fetch_addr(fetch_addr),
        .rsp_take  (rsp_take)
    );

    fbuf_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .PKT_W(PKT_W), .WIN(MAX_BND)) u_store (
        .clk    (clk),
        .wr_en  (rsp_take),
        .wr_base(head + occ[IDX_W-1:0]),
        .wr_cnt (wr_cnt),
        .wr_pkt (fetch_rsp_pkt),
        .rd_base(head + off[IDX_W-1:0]),
        .rd_win (win)
    );

    fbuf_scan #(.WORD_W(WORD_W), .WIN(MAX_BND), .OCC_W(OCC_W)) u_scan (
        .rd_win(win),
        .avail (avail),
        .found (bnd_valid),
        .len   (bnd_len),
        .words (bnd_words)
    );

    assign bnd_pc = rpc;

    // Occupancy, read point, mode and loop state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= FB_LINEAR;
            head     <= '0;
            occ      <= '0;
            off      <= '0;
            fetched  <= '0;
            body_len <= '0;
            rpc      <= RESET_PC;
            lp_first <= '0;
            lp_last  <= '0;
            iters    <= '0;
        end else if (flush) begin
            head    <= '0;
            occ     <= '0;
            off     <= '0;
            fetched <= '0;
            rpc     <= flush_pc;
            if (br_valid) begin
                mode <= FB_LINEAR;
            end else if (loop_start) begin
                mode     <= fits_in ? FB_LOOP_HELD : FB_LOOP_REFETCH;
                lp_first <= loop_first;
                lp_last  <= loop_last;
                iters    <= (loop_count == '0) ? CNT_W'(1) : loop_count;
                body_len <= OCC_W'(span_in) + 1'b1;
            end else if (wrap) begin
                iters <= iters - 1'b1;
            end else begin
                mode <= FB_LINEAR;
            end
        end else begin
            occ <= occ + (rsp_take ? OCC_W'(wr_cnt) : '0)
                       - ((hs && mode != FB_LOOP_HELD) ? OCC_W'(bnd_len) : '0);
            if (rsp_take && mode == FB_LOOP_HELD)
                fetched <= fetched + OCC_W'(wr_cnt);
            if (hs) begin
                if (mode == FB_LOOP_HELD) begin
                    if (wrap) begin
                        off   <= '0;
                        rpc   <= lp_first;
                        iters <= iters - 1'b1;
                    end else begin
                        off <= off + OCC_W'(bnd_len);
                        rpc <= rpc + ADDR_W'(bnd_len);
                    end
                end else begin
                    head <= head + IDX_W'(bnd_len);
                    rpc  <= rpc + ADDR_W'(bnd_len);
                    if (exit_l)
                        mode <= FB_LINEAR;
                end
            end
        end
    end
endmodule

// File: rtl/fbuf_chk.sv
`timescale 1ns/1ps
// Protocol and occupancy checker for bundle_fetch_buffer; attached by bind.
module fbuf_chk #(
    parameter int WORD_W  = 16,
    parameter int ADDR_W  = 16,
    parameter int MAX_BND = 10,
    parameter int DEPTH   = 16,
    parameter int LEN_W   = 4,
    parameter int OCC_W   = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      fetch_req,
    input logic                      br_valid,
    input logic                      loop_start,
    input logic                      bnd_valid,
    input logic                      bnd_ready,
    input logic [LEN_W-1:0]          bnd_len,
    input logic [MAX_BND*WORD_W-1:0] bnd_words,
    input logic [ADDR_W-1:0]         bnd_pc,
    input logic [OCC_W-1:0]          occ
);
    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_valid && !bnd_ready && !br_valid && !loop_start)
        |=> (bnd_valid && $stable(bnd_words) && $stable(bnd_len) && $stable(bnd_pc)));

    // R2
    single_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> !fetch_req);

    // R2
    occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= DEPTH);

    // R3
    bundle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_valid |-> (bnd_len != '0 && int'(bnd_len) <= MAX_BND));

    // R6
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> !bnd_valid);
endmodule

bind bundle_fetch_buffer fbuf_chk #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W),
    .MAX_BND(MAX_BND),
    .DEPTH  (DEPTH),
    .LEN_W  (LEN_W),
    .OCC_W  ($clog2(DEPTH + 1))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_req (fetch_req),
    .br_valid  (br_valid),
    .loop_start(loop_start),
    .bnd_valid (bnd_valid),
    .bnd_ready (bnd_ready),
    .bnd_len   (bnd_len),
    .bnd_words (bnd_words),
    .bnd_pc    (bnd_pc),
    .occ       (occ)
);

// File: tb/sim_bundle_fetch_buffer.sv
`timescale 1ns/1ps
// Bench: address-derived program image, single-outstanding memory model,
// with sweeps over ready patterns, branch timing, latency and loop shapes.
module sim_bundle_fetch_buffer;
    localparam int W = 16, A = 16, P = 4, MB = 10, E = 17;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fetch_req;
    logic [A-1:0]    fetch_addr;
    logic            fetch_rsp_valid = 1'b0;
    logic [P*E-1:0]  fetch_rsp_pkt = '0;
    logic            bnd_valid;
    logic            bnd_ready = 1'b0;
    logic [3:0]      bnd_len;
    logic [MB*W-1:0] bnd_words;
    logic [A-1:0]    bnd_pc;
    logic            br_valid = 1'b0;
    logic [A-1:0]    br_target = '0;
    logic            loop_start = 1'b0;
    logic [A-1:0]    loop_first = '0;
    logic [A-1:0]    loop_last = '0;
    logic [7:0]      loop_count = '0;

    bundle_fetch_buffer u0 (.*);

    always #2.5 clk = ~clk;

    int nchk = 0, nfail = 0, cyc = 0, nreq = 0;
    int mem_cnt = 0, lat = 1;
    logic [A-1:0] mem_addr = '0;
    logic [A-1:0] exp_pc = '0;
    string tag = "R4";
    bit loop_on = 0, zero_cnt = 0, held = 0, finished = 0;
    int m_iters = 0;
    logic [A-1:0] m_first, m_last;
    bit hold_pend = 0;
    logic [MB*W-1:0] h_words;
    logic [3:0] h_len;
    logic [A-1:0] h_pc;
    // Inputs for the next tick.
    bit d_rdy = 1, d_br = 0, d_ls = 0;
    logic [A-1:0] d_tgt, d_first, d_last;
    logic [7:0] d_cnt;

    function automatic bit eob_at(logic [A-1:0] a);
        return (a % 10 == 9) || (a % 7 == 3);
    endfunction
    function automatic logic [W-1:0] dat_at(logic [A-1:0] a);
        return a ^ 16'h3C3C;
    endfunction
    function automatic int len_at(logic [A-1:0] a);
        for (int k = 0; k < MB; k++) if (eob_at(a + A'(k))) return k + 1;
        return MB;
    endfunction
    function automatic logic [A-1:0] end_after(logic [A-1:0] a, int nb);
        logic [A-1:0] p = a;
        for (int i = 0; i < nb; i++) p = p + A'(len_at(p));
        return p - 1'b1;
    endfunction

    task automatic chk(bit ok, string r, logic [MB*W-1:0] act, logic [MB*W-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", r, cyc, act, exp);
        end
    endtask

    // One clock: drive inputs at the falling edge, then model memory and check.
    task automatic tick();
        logic [MB*W-1:0] ew;
        int el;
        @(negedge clk);
        cyc++;
        fetch_rsp_valid = 1'b0;
        if (mem_cnt > 0) begin
            mem_cnt--;
            if (mem_cnt == 0) begin
                fetch_rsp_valid = 1'b1;
                for (int j = 0; j < P; j++)
                    fetch_rsp_pkt[j*E +: E] = {eob_at(mem_addr + A'(j)), dat_at(mem_addr + A'(j))};
            end
        end
        bnd_ready  = d_rdy;
        br_valid   = d_br;   br_target  = d_tgt;
        loop_start = d_ls;   loop_first = d_first;
        loop_last  = d_last; loop_count = d_cnt;
        #1;
        if (hold_pend) begin
            chk(bnd_valid && bnd_words == h_words && bnd_len == h_len && bnd_pc == h_pc,
                "R5 hold", bnd_words, h_words);
            hold_pend = 0;
        end
        if (fetch_req) begin
            // R2: no new request while one is unanswered
            chk(mem_cnt == 0 && !fetch_rsp_valid, "R2 outstanding", MB*W'(mem_cnt), '0);
            mem_addr = fetch_addr;
            mem_cnt  = lat;
            nreq++;
        end
        if (bnd_valid && bnd_ready) begin
            el = len_at(exp_pc);
            ew = '0;
            for (int k = 0; k < MB; k++) if (k < el) ew[k*W +: W] = dat_at(exp_pc + A'(k));
            chk(bnd_pc == exp_pc, tag, bnd_pc, exp_pc);
            chk(int'(bnd_len) == el, "R3 length", bnd_len, el);
            chk(bnd_words == ew, "R3 words", bnd_words, ew);
            tag = "R4";
            if (loop_on && exp_pc + A'(el) - 1'b1 == m_last) begin
                if (m_iters > 1) begin
                    m_iters--;
                    exp_pc = m_first;
                    tag = held ? "R7 replay" : "R8 refetch";
                end else begin
                    loop_on = 0;
                    exp_pc = m_last + 1'b1;
                    tag = zero_cnt ? "R10 single pass" : "R9 exit";
                end
            end else begin
                exp_pc = exp_pc + A'(el);
            end
        end
        if (bnd_valid && !bnd_ready && !d_br && !d_ls) begin
            hold_pend = 1;
            h_words = bnd_words; h_len = bnd_len; h_pc = bnd_pc;
        end
        if (d_br) begin
            exp_pc = d_tgt; loop_on = 0; tag = "R6 branch target";
        end
        if (d_ls) begin
            exp_pc = d_first; loop_on = 1; m_first = d_first; m_last = d_last;
            m_iters = (d_cnt == 0) ? 1 : int'(d_cnt);
            zero_cnt = (d_cnt == 0);
            held = (d_last - d_first) < 16;
            tag = "R4";
        end
        d_br = 0; d_ls = 0;
    endtask

    task automatic run(int n, bit mixed);
        for (int i = 0; i < n; i++) begin
            d_rdy = mixed ? ((cyc % 5) != 3) : 1'b1;
            tick();
        end
    endtask

    initial begin
        int r0, L, pk, it;
        logic [A-1:0] s, e;
        int starts [5] = '{10, 20, 25, 30, 32};
        repeat (3) @(negedge clk);
        #1;
        chk(!bnd_valid, "R1 valid in reset", bnd_valid, 0);
        chk(!fetch_req, "R1 request in reset", fetch_req, 0);
        chk(fetch_addr == 0, "R1 reset address", fetch_addr, 0);
        rst_n = 1'b1;
        #1;
        chk(fetch_req && fetch_addr == 0, "R1 first request", fetch_addr, 0);
        mem_addr = fetch_addr; mem_cnt = lat; nreq++;
        // Linear stream, several latencies and ready patterns.
        for (int l = 1; l <= 3; l++) begin
            lat = l;
            run(60, l != 1);
        end
        // Branch sweep over timing, latency and target alignment.
        for (int t = 0; t < 30; t++) begin
            lat = 1 + t % 3;
            run(t % 7 + 2, 1);
            d_tgt = A'(300 + t * 13 + t % 4); d_br = 1; d_rdy = (t % 2 == 0);
            tick();
            run(25, t % 3 == 0);
        end
        // Loop sweep across the 16-word body limit and counts 0..3.
        foreach (starts[si]) begin
            for (int k = 1; k <= 6; k++) begin
                s = A'(starts[si]);
                e = end_after(s, k);
                L = int'(e - s) + 1;
                pk = (L + P - 1) / P;
                it = (k % 4 == 0) ? 1 : k % 4;
                lat = 1 + k % 2;
                d_first = s; d_last = e; d_cnt = 8'(k % 4); d_ls = 1;
                r0 = nreq;
                tick();
                for (int g = 0; g < 800 && loop_on; g++) begin
                    d_rdy = (cyc % 4) != 1;
                    tick();
                end
                chk(!loop_on, "R9 loop completes", loop_on, 0);
                if (L <= 16)
                    chk(nreq - r0 == pk, "R7 fetch count", nreq - r0, pk);
                else
                    chk(nreq - r0 >= it * pk, "R8 fetch count", nreq - r0, it * pk);
                run(15, 0);
            end
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(150000 * 5);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule